// File: doc/BRIEF.md
# I2C Bus Master START Generator

This block produces the START condition that opens every transfer of an I2C bus master. Software writes the command register with its start bit set. If both bus lines are seen idle (high), the block times two equal periods with a reloadable down-counter. At the end of the first period it pulls SDA low while SCL stays released, which is the START. At the end of the second period it clears the start bit and leaves SDA held low. The next transfer phase takes the bus over from that point.

Both lines are open-drain. The block drives a low-enable for each line and reads the resolved line levels back through a two-flop synchronizer. If a line is already low when the command is taken, or SCL is seen low before SDA has been pulled, another master owns the bus. The block then flags a collision, releases both lines and returns to idle.

While a START runs, the block refuses a transmit-buffer write, raises a write-collision flag and ignores command-register writes, so commands cannot queue. Status flags are sticky until a clear strobe.

Top module: `i2c_start_gen`

## Requirements
- R1: A command write with bit 0 of `cmd_wdata` set, taken while idle, starts a START only if both synchronized lines are high. `cmd_q[0]` then reads 1 from the next cycle.
- R2: With reload value R, `sda_drive_low` rises exactly R+1 clock edges after the edge that takes the command. `scl_drive_low` is never asserted.
- R3: `start_flag` and `irq_flag` become 1 in the same cycle that `sda_drive_low` rises.
- R4: `cmd_q[0]` clears exactly 2*(R+1) edges after the command edge. `sda_drive_low` stays 1 afterwards, until reset or a collision.
- R5: If either line is low when a start command is taken, `bcol_flag` sets on that edge and `cmd_q[0]` stays 0. A line-level change reaches the control logic two edges after it is sampled.
- R6: If SCL is seen low during the first period, the START aborts. `bcol_flag` sets, `cmd_q[0]` returns to 0, SDA is never pulled and `start_flag` stays 0.
- R7: A `buf_wr` while a START is in progress sets `wcol_flag` and leaves `buf_q` unchanged. While idle, `buf_wr` loads `buf_wdata` into `buf_q` and does not set `wcol_flag`.
- R8: A `cmd_wr` while a START is in progress changes no bit of `cmd_q`.
- R9: The four flags are sticky. `flag_clr` clears all of them, and a set in the same cycle wins over the clear.
- R10: After reset, all flags, `cmd_q`, `buf_q` and both drive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload | input | 7 | Baud-period reload value R (period = R+1 clocks) |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 5 | Command write data, bit 0 = start enable |
| cmd_q | output | 5 | Command register contents |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| buf_q | output | 8 | Transmit buffer contents |
| sda_in | input | 1 | Resolved SDA line level (asynchronous) |
| scl_in | input | 1 | Resolved SCL line level (asynchronous) |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| flag_clr | input | 1 | Clears all sticky flags |
| start_flag | output | 1 | START seen on the bus |
| irq_flag | output | 1 | Serial-port interrupt flag |
| bcol_flag | output | 1 | Bus collision flag |
| wcol_flag | output | 1 | Write collision flag |

## Verification
A wrong counter load or decrement shifts the rise of `sda_drive_low` and the fall of `cmd_q[0]` by whole cycles. The bench therefore compares both at every cycle of a START, for many reload values. A state machine stuck outside idle shows up as `cmd_q[0]` not clearing at its exact edge, and as later buffer writes being refused. A missed or late collision shows up within R+3 cycles, either as SDA being pulled or as `bcol_flag` staying low. An off-by-one in the synchronizer depth moves the last injection point that still aborts.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_TAIL = 2'd2
  } start_st_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_brg.sv
module i2cs_brg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= reload;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int CMD_W = 5,
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_s,
  input  logic             brg_expired,
  output logic             brg_load,
  output logic             brg_run,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_q,
  input  logic             buf_wr,
  input  logic [BUF_W-1:0] buf_wdata,
  output logic [BUF_W-1:0] buf_q,
  input  logic             flag_clr,
  output logic             sda_low,
  output logic             start_flag,
  output logic             irq_flag,
  output logic             bcol_flag,
  output logic             wcol_flag
);
  start_st_e st;
  logic busy, lines_high, take_cmd, go, pre_col, lead_col, lead_done, tail_done;

  assign busy       = (st != ST_IDLE);
  assign lines_high = sda_s & scl_s;
  assign take_cmd   = cmd_wr & ~busy;
  assign go         = take_cmd & cmd_wdata[0] & lines_high;
  assign pre_col    = take_cmd & cmd_wdata[0] & ~lines_high;
  assign lead_col   = (st == ST_LEAD) & ~lines_high;
  assign lead_done  = (st == ST_LEAD) & lines_high & brg_expired;
  assign tail_done  = (st == ST_TAIL) & brg_expired;

  assign brg_load = go | lead_done;
  assign brg_run  = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (go)        st <= ST_LEAD;
        ST_LEAD: if (lead_col)  st <= ST_IDLE;
                 else if (lead_done) st <= ST_TAIL;
        ST_TAIL: if (tail_done) st <= ST_IDLE;
        default:                st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (take_cmd) begin
      cmd_q <= {cmd_wdata[CMD_W-1:1], go};
    end else if (lead_col || tail_done) begin
      cmd_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                buf_q <= '0;
    else if (buf_wr && !busy)  buf_q <= buf_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sda_low <= 1'b0;
    else if (lead_col || pre_col)  sda_low <= 1'b0;
    else if (lead_done)            sda_low <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_flag <= 1'b0;
      irq_flag   <= 1'b0;
      bcol_flag  <= 1'b0;
      wcol_flag  <= 1'b0;
    end else begin
      start_flag <= lead_done            | (start_flag & ~flag_clr);
      irq_flag   <= lead_done            | (irq_flag   & ~flag_clr);
      bcol_flag  <= (pre_col | lead_col) | (bcol_flag  & ~flag_clr);
      wcol_flag  <= (buf_wr & busy)      | (wcol_flag  & ~flag_clr);
    end
  end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
  parameter int RELOAD_W    = 7,
  parameter int CMD_W       = 5,
  parameter int BUF_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_wdata,
  output logic [CMD_W-1:0]    cmd_q,
  input  logic                buf_wr,
  input  logic [BUF_W-1:0]    buf_wdata,
  output logic [BUF_W-1:0]    buf_q,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_drive_low,
  output logic                scl_drive_low,
  input  logic                flag_clr,
  output logic                start_flag,
  output logic                irq_flag,
  output logic                bcol_flag,
  output logic                wcol_flag
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  logic brg_load, brg_run, brg_expired;

  i2cs_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );

  i2cs_brg #(.W(RELOAD_W)) u_brg (
    .clk(clk), .rst_n(rst_n), .load(brg_load), .run(brg_run),
    .reload(reload), .expired(brg_expired)
  );

  i2cs_ctrl #(.CMD_W(CMD_W), .BUF_W(BUF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sda_s(lines_s[0]), .scl_s(lines_s[1]),
    .brg_expired(brg_expired), .brg_load(brg_load), .brg_run(brg_run),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
    .flag_clr(flag_clr), .sda_low(sda_drive_low),
    .start_flag(start_flag), .irq_flag(irq_flag),
    .bcol_flag(bcol_flag), .wcol_flag(wcol_flag)
  );

  assign scl_drive_low = 1'b0;
endmodule

// File: rtl/i2cs_start_gen_chk.sv
module i2cs_start_gen_chk #(
  parameter int CMD_W = 5,
  parameter int BUF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic [CMD_W-1:0] cmd_q,
  input logic             buf_wr,
  input logic [BUF_W-1:0] buf_q,
  input logic             sda_drive_low,
  input logic             start_flag,
  input logic             irq_flag,
  input logic             bcol_flag,
  input logic             wcol_flag
);
  a_r3_s_with_sda: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> start_flag && irq_flag);

  a_r4_sda_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> bcol_flag);

  a_r6_col_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol_flag) |-> !sda_drive_low && !cmd_q[0]);

  a_r7_buf_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && buf_wr) |=> $stable(buf_q) && wcol_flag);

  a_r8_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && cmd_wr) |=> $stable(cmd_q[CMD_W-1:1]));
endmodule

bind i2c_start_gen i2cs_start_gen_chk #(.CMD_W(CMD_W), .BUF_W(BUF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_q(cmd_q),
  .buf_wr(buf_wr), .buf_q(buf_q), .sda_drive_low(sda_drive_low),
  .start_flag(start_flag), .irq_flag(irq_flag),
  .bcol_flag(bcol_flag), .wcol_flag(wcol_flag)
);

// File: tb/tb_i2c_start_gen.sv
module tb_i2c_start_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] reload = '0;
  logic       cmd_wr = 1'b0;
  logic [4:0] cmd_wdata = '0;
  logic [4:0] cmd_q;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_q;
  logic       sda_in, scl_in, sda_drive_low, scl_drive_low;
  logic       flag_clr = 1'b0;
  logic       start_flag, irq_flag, bcol_flag, wcol_flag;
  logic       frc_sda = 1'b0, frc_scl = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign sda_in = ~sda_drive_low & ~frc_sda;
  assign scl_in = ~scl_drive_low & ~frc_scl;

  i2c_start_gen dut (
    .clk(clk), .rst_n(rst_n), .reload(reload),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
    .sda_in(sda_in), .scl_in(scl_in),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .flag_clr(flag_clr), .start_flag(start_flag), .irq_flag(irq_flag),
    .bcol_flag(bcol_flag), .wcol_flag(wcol_flag)
  );

  function automatic bit exp_sda(int k, int r);
    return k >= r + 1;
  endfunction

  function automatic bit exp_busy(int k, int r);
    return k < 2 * (r + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    frc_sda = 0; frc_scl = 0; cmd_wr = 0; buf_wr = 0; flag_clr = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // Full START with lockout probes during the first busy cycle
  task automatic run_start(input int r, input bit probe);
    logic [7:0] bv;
    bv = 8'($urandom);
    do_reset();
    reload = 7'(r);
    buf_wr = 1; buf_wdata = bv;
    @(negedge clk);
    buf_wr = 0;
    chk(buf_q == bv && !wcol_flag, "R7 idle write", buf_q, bv);
    cmd_wr = 1; cmd_wdata = 5'b00001;
    @(negedge clk);
    cmd_wr = 0;
    chk(cmd_q == 5'b00001, "R1 accepted", cmd_q, 1);
    if (probe) begin
      buf_wr = 1; buf_wdata = ~bv;
      cmd_wr = 1; cmd_wdata = 5'b11110;
    end
    for (int k = 1; k <= 2 * r + 4; k++) begin
      @(negedge clk);
      buf_wr = 0; cmd_wr = 0;
      if (probe && k == 1) begin
        chk(buf_q == bv && wcol_flag, "R7 busy write", buf_q, bv);
        chk(cmd_q == 5'b00001, "R8 cmd locked", cmd_q, 1);
      end
      chk(sda_drive_low == exp_sda(k, r), "R2 sda timing", sda_drive_low, exp_sda(k, r));
      chk(start_flag == exp_sda(k, r) && irq_flag == exp_sda(k, r), "R3 flags with sda",
          start_flag, exp_sda(k, r));
      chk(cmd_q[0] == exp_busy(k, r), "R4 enable clear", cmd_q[0], exp_busy(k, r));
      chk(!scl_drive_low, "R2 scl released", scl_drive_low, 0);
    end
    chk(cmd_q == 5'b00000, "R8 no queued bits", cmd_q, 0);
    chk(!bcol_flag, "R6 no collision", bcol_flag, 0);
  endtask

  // SCL pulled low before edge j of the first period
  task automatic run_col(input int r, input int j);
    do_reset();
    reload = 7'(r);
    cmd_wr = 1; cmd_wdata = 5'b00001;
    @(negedge clk);
    cmd_wr = 0;
    for (int k = 1; k < j; k++) @(negedge clk);
    frc_scl = 1;
    repeat (r + 4) @(negedge clk);
    chk(bcol_flag, "R6 collision flag", bcol_flag, 1);
    chk(!sda_drive_low && !start_flag, "R6 no START", sda_drive_low, 0);
    chk(cmd_q[0] == 0, "R6 enable cleared", cmd_q[0], 0);
    frc_scl = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1c2a));
    rst_n = 0;
    @(negedge clk);
    chk(cmd_q == 0 && buf_q == 0 && !sda_drive_low && !scl_drive_low &&
        !start_flag && !irq_flag && !bcol_flag && !wcol_flag, "R10 reset state", 0, 0);

    // Directed corner cases
    run_start(0, 1);
    run_start(1, 1);
    run_start(127, 0);
    run_col(2, 1);
    run_col(9, 8);   // latest injection that still aborts (j = R-1)

    // Line already low at accept
    do_reset();
    reload = 7'd3;
    frc_sda = 1; frc_scl = 1;
    repeat (3) @(negedge clk);
    cmd_wr = 1; cmd_wdata = 5'b00001;
    @(negedge clk);
    cmd_wr = 0;
    chk(bcol_flag && cmd_q[0] == 0, "R5 busy bus", bcol_flag, 1);
    repeat (6) @(negedge clk);
    chk(!sda_drive_low && !start_flag, "R5 no START", start_flag, 0);

    // One line low only, still refused
    do_reset();
    frc_scl = 1;
    repeat (3) @(negedge clk);
    cmd_wr = 1; cmd_wdata = 5'b00001;
    @(negedge clk);
    cmd_wr = 0;
    chk(bcol_flag && cmd_q[0] == 0, "R5 scl low", bcol_flag, 1);

    // Sync latency: line low only one edge before accept is not yet seen
    do_reset();
    reload = 7'd2;
    frc_scl = 1;
    cmd_wr = 1; cmd_wdata = 5'b00001;
    @(negedge clk);
    cmd_wr = 0;
    chk(cmd_q[0] == 1 && !bcol_flag, "R5 two-flop latency", cmd_q[0], 1);
    frc_scl = 0;

    // Sticky flags and clear, set wins over clear
    run_start(1, 1);
    repeat (5) @(negedge clk);
    chk(start_flag && irq_flag && wcol_flag, "R9 sticky", start_flag, 1);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    chk(!start_flag && !irq_flag && !wcol_flag && !bcol_flag, "R9 cleared", start_flag, 0);
    chk(sda_drive_low, "R4 sda stays low", sda_drive_low, 1);
    do_reset();
    reload = 7'd4;
    cmd_wr = 1; cmd_wdata = 5'b00001;
    @(negedge clk);
    cmd_wr = 0;
    buf_wr = 1; flag_clr = 1;
    @(negedge clk);
    buf_wr = 0; flag_clr = 0;
    chk(wcol_flag, "R9 set wins", wcol_flag, 1);

    // Random trials
    for (int t = 0; t < 40; t++) begin
      int r;
      r = ($urandom % 4 == 0) ? int'($urandom % 128) : int'($urandom % 16);
      if ($urandom % 2 == 0 && r >= 2) run_col(r, 1 + int'($urandom % (r - 1)));
      else run_start(r, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule